// File: doc/BRIEF.md
# PSRAM Power-State Sequencer

This block owns the two chip-enable lines of an asynchronous pseudo-static RAM and walks the memory through its power states. These are the initial hold after supply-up, normal operation, standby, and deep power-down. The primary select is active low and opens the memory for accesses. The secondary line keeps the core powered while it is high and puts the memory into deep power-down when it is low. Every wait is a parameterised number of clock cycles, so an integrator converts the nanosecond and microsecond limits of the memory into cycles for the clock in use.

A separate access controller performs reads and writes only while `ready_o` is high. The system asks for deep power-down with a sleep request. The request takes effect only once the access controller reports idle. The sequencer first parks the memory in standby for a short dwell, then lowers the secondary line. A wake request raises that line again, and the long initialisation hold is repeated before access is granted. Deep power-down stops refresh, so the sequencer raises a sticky lost-contents flag that the host clears with an acknowledge.

Top module: `psram_pwr_seq`

## Requirements
- R1: During and right after reset, `mem_sel_n_o`=1, `mem_wake_o`=1, `ready_o`=0 and `data_lost_o`=0.
- R2: While `supply_ok_i` is low after reset, the outputs stay at their reset values. Once the clock edge samples `supply_ok_i` high, both lines stay high for exactly INIT_CYC further cycles. On the next edge `ready_o` goes to 1 and `mem_sel_n_o` goes to 0.
- R3: If `supply_ok_i` is sampled low in any state, the next cycle has `ready_o`=0, `mem_sel_n_o`=1 and `mem_wake_o`=1, and the power-on hold of R2 restarts. `data_lost_o` keeps its value.
- R4: In the ready state, a sleep request does nothing while `acc_idle_i` is 0. The ready state and the low select are kept.
- R5: On the edge that samples `sleep_req_i`=1 with `acc_idle_i`=1 in the ready state, `ready_o` falls and `mem_sel_n_o` rises. Both lines then stay high for exactly STBY_CYC cycles before `mem_wake_o` falls.
- R6: Once `mem_wake_o` has fallen, it stays low for at least PD_MIN_CYC cycles. A wake request is sampled only after that window, so a wake pulse during the window is lost.
- R7: On the edge that samples `wake_req_i`=1 in deep power-down, `mem_wake_o` rises while `mem_sel_n_o` is already 1. Both stay high for exactly INIT_CYC cycles, and then `ready_o` goes to 1.
- R8: `data_lost_o` rises on the same edge that `mem_wake_o` falls for deep power-down. It holds until an edge samples `lost_ack_i`=1. If an acknowledge arrives on the setting edge, the set wins.
- R9: `mem_wake_o`=0 is never seen with `mem_sel_n_o`=0, and `ready_o`=1 is only seen with `mem_sel_n_o`=0 and `mem_wake_o`=1.
- R10: A sleep request held during the power-on hold neither shortens nor lengthens that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Memory supply is stable |
| sleep_req_i | input | 1 | Level request for deep power-down |
| wake_req_i | input | 1 | Level request to leave deep power-down |
| acc_idle_i | input | 1 | Access controller has no cycle in flight |
| lost_ack_i | input | 1 | Host acknowledge that clears the lost flag |
| ready_o | output | 1 | Access is allowed |
| mem_sel_n_o | output | 1 | Primary memory select, active low |
| mem_wake_o | output | 1 | Secondary enable, low puts the memory in deep power-down |
| data_lost_o | output | 1 | Contents lost to deep power-down, sticky |

## Verification
The bench measures the exact edge on which each dwell ends: the power-on hold, the standby dwell before the secondary line falls, and the repeated hold after wake-up. A design off by one cycle would grant access early or lower the secondary line before the select has settled high. It holds a sleep request against a busy access controller, which a design that drops the idle qualifier would honour in the middle of an access. It also sends a wake pulse inside the minimum power-down window, which a design that samples wake too early would act on. It makes the acknowledge and the set of the lost flag coincide, and it cuts the supply both in deep power-down and in the ready state. This exposes designs that lose the flag on supply loss or that leave the secondary line low.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;
  typedef enum logic [2:0] {
    ST_POR_WAIT,
    ST_INIT_HOLD,
    ST_READY,
    ST_STANDBY,
    ST_PD_ENTER,
    ST_POWER_DOWN,
    ST_PD_EXIT
  } pwr_state_e;
endpackage

// File: rtl/psram_dwell_timer.sv
module psram_dwell_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (cnt_q != lim_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == lim_i);

  // count never runs past the limit of an unchanged state (R2, R5, R6, R7)
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && cnt_q <= lim_i) |=> (cnt_q <= $past(lim_i)));
endmodule

// File: rtl/psram_lost_flag.sv
module psram_lost_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic lost_o
);
  logic lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lost_q <= 1'b0;
    else if (set_i) lost_q <= 1'b1;
    else if (ack_i) lost_q <= 1'b0;
  end

  assign lost_o = lost_q;

  assert_lost_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> lost_q);
  assert_lost_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_q && !ack_i) |=> lost_q);
endmodule

// File: rtl/psram_pwr_fsm.sv
module psram_pwr_fsm
  import psram_pwr_pkg::*;
#(
  parameter int INIT_CYC   = 50000,
  parameter int STBY_CYC   = 2,
  parameter int PD_MIN_CYC = 10,
  parameter int CNT_W      = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             supply_ok_i,
  input  logic             sleep_req_i,
  input  logic             wake_req_i,
  input  logic             acc_idle_i,
  input  logic             dwell_done_i,
  output logic [CNT_W-1:0] dwell_lim_o,
  output logic             dwell_clr_o,
  output logic             pd_entry_o,
  output logic             ready_o,
  output logic             sel_n_o,
  output logic             wake_o
);
  localparam logic [CNT_W-1:0] LimInit = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] LimStby = CNT_W'(STBY_CYC - 1);
  localparam logic [CNT_W-1:0] LimPd   = CNT_W'(PD_MIN_CYC - 1);

  pwr_state_e state_q, state_n;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_POR_WAIT:   if (supply_ok_i) state_n = ST_INIT_HOLD;
      ST_INIT_HOLD:  if (dwell_done_i) state_n = ST_READY;
      ST_READY:      if (sleep_req_i && acc_idle_i) state_n = ST_STANDBY;
      ST_STANDBY:    if (dwell_done_i) state_n = ST_PD_ENTER;
      ST_PD_ENTER:   if (dwell_done_i) state_n = ST_POWER_DOWN;
      ST_POWER_DOWN: if (wake_req_i) state_n = ST_PD_EXIT;
      ST_PD_EXIT:    if (dwell_done_i) state_n = ST_READY;
      default:       state_n = ST_POR_WAIT;
    endcase
    if (!supply_ok_i) state_n = ST_POR_WAIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_POR_WAIT;
    else         state_q <= state_n;
  end

  always_comb begin
    unique case (state_q)
      ST_INIT_HOLD, ST_PD_EXIT: dwell_lim_o = LimInit;
      ST_STANDBY:               dwell_lim_o = LimStby;
      ST_PD_ENTER:              dwell_lim_o = LimPd;
      default:                  dwell_lim_o = '0;
    endcase
  end

  assign dwell_clr_o = (state_n != state_q);
  assign pd_entry_o  = (state_n == ST_PD_ENTER) && (state_q != ST_PD_ENTER);
  assign ready_o     = (state_q == ST_READY);
  assign sel_n_o     = (state_q != ST_READY);
  assign wake_o      = (state_q != ST_PD_ENTER) && (state_q != ST_POWER_DOWN);

  // deep power-down only from standby (R5)
  assert_pd_from_stby_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_PD_ENTER) |-> ($past(state_q) == ST_STANDBY));
  // busy access controller blocks sleep (R4)
  assert_sleep_defer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_READY && !acc_idle_i && supply_ok_i) |=> (state_q == ST_READY));
  // supply loss forces restart (R3)
  assert_supply_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> (state_q == ST_POR_WAIT));
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int INIT_CYC   = 50000,
  parameter int STBY_CYC   = 2,
  parameter int PD_MIN_CYC = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic acc_idle_i,
  input  logic lost_ack_i,
  output logic ready_o,
  output logic mem_sel_n_o,
  output logic mem_wake_o,
  output logic data_lost_o
);
  localparam int MAX_A  = (INIT_CYC > STBY_CYC) ? INIT_CYC : STBY_CYC;
  localparam int MAX_C  = (MAX_A > PD_MIN_CYC) ? MAX_A : PD_MIN_CYC;
  localparam int CNT_W  = $clog2(MAX_C + 1) + 1;
  localparam int LOW_W  = $clog2(PD_MIN_CYC + 1) + 1;

  logic [CNT_W-1:0] dwell_lim;
  logic             dwell_clr, dwell_done, pd_entry;

  psram_pwr_fsm #(
    .INIT_CYC  (INIT_CYC),
    .STBY_CYC  (STBY_CYC),
    .PD_MIN_CYC(PD_MIN_CYC),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .supply_ok_i (supply_ok_i),
    .sleep_req_i (sleep_req_i),
    .wake_req_i  (wake_req_i),
    .acc_idle_i  (acc_idle_i),
    .dwell_done_i(dwell_done),
    .dwell_lim_o (dwell_lim),
    .dwell_clr_o (dwell_clr),
    .pd_entry_o  (pd_entry),
    .ready_o     (ready_o),
    .sel_n_o     (mem_sel_n_o),
    .wake_o      (mem_wake_o)
  );

  psram_dwell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(dwell_clr),
    .lim_i  (dwell_lim),
    .done_o (dwell_done)
  );

  psram_lost_flag u_lost (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (pd_entry),
    .ack_i (lost_ack_i),
    .lost_o(data_lost_o)
  );

  // window counters for the checks below
  logic [CNT_W-1:0] hi_cnt_q;
  logic [LOW_W-1:0] lo_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
      lo_cnt_q <= '0;
    end else begin
      if (!(mem_sel_n_o && mem_wake_o))       hi_cnt_q <= '0;
      else if (hi_cnt_q != CNT_W'(INIT_CYC))  hi_cnt_q <= hi_cnt_q + 1'b1;
      if (mem_wake_o)                         lo_cnt_q <= '0;
      else if (lo_cnt_q != LOW_W'(PD_MIN_CYC)) lo_cnt_q <= lo_cnt_q + 1'b1;
    end
  end

  assert_init_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (hi_cnt_q >= CNT_W'(INIT_CYC)));
  assert_pd_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_wake_o) && $past(supply_ok_i)) |-> (lo_cnt_q >= LOW_W'(PD_MIN_CYC)));
  assert_enable_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_wake_o |-> mem_sel_n_o);
  assert_ready_active_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!mem_sel_n_o && mem_wake_o));
endmodule

// File: tb/psram_pwr_seq_bench.sv
module psram_pwr_seq_bench;
  localparam int INIT = 40;
  localparam int STBY = 2;
  localparam int PDM  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, sleep_req = 1'b0, wake_req = 1'b0;
  logic acc_idle = 1'b0, lost_ack = 1'b0;
  logic ready, sel_n, wake, lost;

  always #4 clk = ~clk;

  psram_pwr_seq #(.INIT_CYC(INIT), .STBY_CYC(STBY), .PD_MIN_CYC(PDM)) u_psram_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .supply_ok_i(supply_ok), .sleep_req_i(sleep_req),
    .wake_req_i(wake_req), .acc_idle_i(acc_idle), .lost_ack_i(lost_ack),
    .ready_o(ready), .mem_sel_n_o(sel_n), .mem_wake_o(wake), .data_lost_o(lost)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int q_cyc[$];
  logic [3:0] q_val[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  // expected {ready, sel_n, wake, lost} after the edge numbered at
  task automatic expect_at(input int at, input logic [3:0] v, input string tag);
    q_cyc.push_back(at);
    q_val.push_back(v);
    q_tag.push_back(tag);
  endtask

  task automatic wait_to(input int at);
    while (cyc < at) @(negedge clk);
  endtask

  // monitor: scoreboard pops and continuous rule checks
  always @(negedge clk) begin
    if (rst_n) begin
      while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
        int c;
        logic [3:0] v;
        string t;
        c = q_cyc.pop_front();
        v = q_val.pop_front();
        t = q_tag.pop_front();
        n_chk++;
        if (c != cyc || {ready, sel_n, wake, lost} !== v) begin
          n_fail++;
          $display("FAIL %s cyc %0d: actual rdy/sel_n/wake/lost=%b expected %b", t, cyc,
                   {ready, sel_n, wake, lost}, v);
        end
      end
      if (!wake) begin
        n_chk++;
        if (sel_n !== 1'b1) begin
          n_fail++;
          $display("FAIL R9 select low in power-down: actual sel_n=%b expected 1", sel_n);
        end
      end
      if (ready) begin
        n_chk++;
        if ({sel_n, wake} !== 2'b01) begin
          n_fail++;
          $display("FAIL R9 ready with wrong enables: actual %b expected 01", {sel_n, wake});
        end
      end
    end
  end

  bit done = 1'b0;

  initial begin
    int c0, c1, c2, c3, c4, c5, c6;
    repeat (3) @(negedge clk);
    n_chk++;
    if ({ready, sel_n, wake, lost} !== 4'b0110) begin
      n_fail++;
      $display("FAIL R1 in reset: actual %b expected 0110", {ready, sel_n, wake, lost});
    end
    rst_n = 1'b1;
    // R1 / R2: no supply, nothing moves
    expect_at(cyc + 1, 4'b0110, "R1");
    expect_at(cyc + 5, 4'b0110, "R2 stall");
    wait_to(cyc + 5);

    // R2 / R10: power-on hold with sleep held, controller busy
    c0 = cyc;
    supply_ok = 1'b1; sleep_req = 1'b1;
    expect_at(c0 + INIT,     4'b0110, "R10 hold");
    expect_at(c0 + INIT + 1, 4'b1010, "R2 ready");
    expect_at(c0 + INIT + 5, 4'b1010, "R4 defer");
    wait_to(c0 + INIT + 5);

    // R5: idle lets sleep through
    c1 = cyc;
    acc_idle = 1'b1;
    expect_at(c1 + 1,        4'b0110, "R5 standby");
    expect_at(c1 + STBY,     4'b0110, "R5 dwell");
    expect_at(c1 + STBY + 1, 4'b0101, "R8 set");
    wait_to(c1 + 1);
    sleep_req = 1'b0;
    // R6: wake pulse inside the minimum window is lost
    wait_to(c1 + STBY + 2);
    wake_req = 1'b1;
    wait_to(c1 + STBY + 3);
    wake_req = 1'b0;
    c2 = c1 + STBY + 1 + PDM + 3;
    expect_at(c2, 4'b0101, "R6 still down");
    wait_to(c2);
    lost_ack = 1'b1;
    expect_at(c2 + 1, 4'b0100, "R8 ack");
    wait_to(c2 + 1);
    lost_ack = 1'b0;

    // R7: wake and re-hold
    c3 = c2 + 2;
    wait_to(c3);
    wake_req = 1'b1;
    expect_at(c3 + 1,        4'b0110, "R7 wake order");
    expect_at(c3 + INIT,     4'b0110, "R7 hold");
    expect_at(c3 + INIT + 1, 4'b1010, "R7 ready");
    wait_to(c3 + 1);
    wake_req = 1'b0;

    // R8: ack and set on the same edge, set wins
    c4 = c3 + INIT + 3;
    wait_to(c4);
    sleep_req = 1'b1;
    expect_at(c4 + 1,        4'b0110, "R5 standby 2");
    expect_at(c4 + STBY + 1, 4'b0101, "R8 set wins");
    wait_to(c4 + 1);
    sleep_req = 1'b0;
    wait_to(c4 + STBY);
    lost_ack = 1'b1;
    wait_to(c4 + STBY + 1);
    lost_ack = 1'b0;

    // R3: supply loss in deep power-down
    c5 = c4 + STBY + PDM + 4;
    wait_to(c5);
    supply_ok = 1'b0;
    expect_at(c5 + 1, 4'b0111, "R3 pd loss");
    wait_to(c5 + 3);
    supply_ok = 1'b1;
    expect_at(c5 + INIT + 3, 4'b0111, "R3 re-hold");
    expect_at(c5 + INIT + 4, 4'b1011, "R3 ready");

    // R3: supply loss while ready
    c6 = c5 + INIT + 6;
    wait_to(c6);
    supply_ok = 1'b0;
    expect_at(c6 + 1, 4'b0111, "R3 ready loss");
    wait_to(c6 + 3);
    n_chk++;
    if (q_cyc.size() != 0) begin
      n_fail++;
      $display("FAIL R3 pending expectations: actual %0d expected 0", q_cyc.size());
    end
    done = 1'b1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule